// File: doc/BRIEF.md
# Bus-Mapped Bidirectional Port Slice with Pull-Up Control

This block is one slice of a general-purpose port, eight pins wide by default. A processor reaches it through a small register window with four word slots, and on the pin side it presents an output enable, an output value and an input value for each pin. Each pin has a data latch and a direction setting. A pull-up enable register chooses which pins get a pull-up. The pull-up reaches the pin only while the pin is an input and is not taken over by the segment-mode override input.

A parameter picks one of three variants. In the first, each pin has its own direction bit. In the second, bit 0 of the direction register sets the direction of the whole slice. The third is an output-only slice: bit 0 of the same register enables all eight drivers at once. While that bit is clear, the pins float with pull-ups on, and this is the state the slice comes out of reset in.

Top module: `gpioPortSlice`

## Requirements
- R1: After reset the data latch, the direction/control register and the pull-up register all read 0. Every pin has its output enable low. The output-only variant has every pull-up active after reset, and the other two variants have none.
- R2: In the per-pin variant a direction bit of 1 drives its pin (pinOe high) and a 0 releases it, starting the cycle after the write to offset 1.
- R3: A read of offset 0 returns the data latch bit for each pin that is an output.
- R4: A read of offset 0 returns the pinIn level for each pin that is an input.
- R5: A write to offset 0 changes only the latch. It leaves pinOe unchanged, and an input pin stays undriven. The value written appears on pinOut and is driven once the pin is later made an output.
- R6: An effective pull-up (pullEn) is active only where the pull-up register bit is 1 and the pin is an input. It is never active on an output pin.
- R7: In the per-pin and grouped variants a pin whose segMode bit is 1 never has an effective pull-up, whatever the pull-up register holds.
- R8: In the grouped variant bit 0 of offset 1 sets every pin to output (1) or input (0). Only that bit is stored, and bits 7..1 read as 0.
- R9: In the output-only variant, control bit 0 of offset 1 at 0 leaves all pins undriven with all pull-ups active. At 1 all pins drive the latch and no pull-up is active.
- R10: The register map is offset 0 for the data latch, offset 1 for direction/control and offset 2 for pull-up enables. Offset 3 reads 0 and ignores writes. A write with busWrEn high takes effect at the next rising clock edge, and reads are combinational.
- R11: In the output-only variant a read of offset 0 returns the latch, independent of pinIn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 2 | Register offset |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for the addressed register (combinational) |
| pinIn | input | 8 | Sampled pin levels |
| segMode | input | 8 | Per-pin segment-mode override that suppresses pull-ups |
| pinOe | output | 8 | Per-pin output enable |
| pinOut | output | 8 | Per-pin output value (data latch) |
| pullEn | output | 8 | Per-pin effective pull-up enable |

## Verification
The case that is hardest to reach from the ports is a value that reaches the latch while its pin is an input. The only trace such a value leaves is on pinOut. It is not read back at offset 0 until the direction flips, so a lost or corrupted write stays hidden until later. The stimulus writes data with the direction cleared, confirms that pinOe stays low and that reads follow pinIn, and then turns the pins into outputs to read the stored value back. A long stretch of random writes, addresses, pin levels and segment masks follows, run on all three variants side by side against a behavioural model. This covers partial direction masks mixed with segment overrides.

// File: rtl/gpioSlicePkg.sv
package gpioSlicePkg;

  typedef enum logic [1:0] {
    KIND_BIDIR   = 2'd0,
    KIND_GROUPED = 2'd1,
    KIND_OUTONLY = 2'd2
  } portKind_e;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_PULL = 2'd2,
    SEL_NONE = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrData;
    logic   wrDir;
    logic   wrPull;
    rdSel_e rdSel;
  } sliceStrobe_t;

endpackage

// File: rtl/gpioSliceCtrl.sv
module gpioSliceCtrl
  import gpioSlicePkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output sliceStrobe_t      strobe
);
  localparam logic [ADDR_W-1:0] OFF_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_DIR  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFF_PULL = ADDR_W'(2);

  always_comb begin
    strobe = '{wrData: 1'b0, wrDir: 1'b0, wrPull: 1'b0, rdSel: SEL_NONE};
    unique case (busAddr)
      OFF_DATA: begin strobe.rdSel = SEL_DATA; strobe.wrData = busWrEn; end
      OFF_DIR:  begin strobe.rdSel = SEL_DIR;  strobe.wrDir  = busWrEn; end
      OFF_PULL: begin strobe.rdSel = SEL_PULL; strobe.wrPull = busWrEn; end
      default:  strobe.rdSel = SEL_NONE;
    endcase
  end

  // R10: at most one register is written per cycle
  always_comb begin
    assert_one_target_R10 : assert ($countones({strobe.wrData, strobe.wrDir, strobe.wrPull}) <= 1);
  end
endmodule

// File: rtl/gpioSliceDatapath.sv
module gpioSliceDatapath
  import gpioSlicePkg::*;
#(
  parameter int        WIDTH = 8,
  parameter portKind_e KIND  = KIND_BIDIR
) (
  input  logic             clk,
  input  logic             rstN,
  input  sliceStrobe_t     strobe,
  input  logic [WIDTH-1:0] busWrData,
  output logic [WIDTH-1:0] busRdData,
  input  logic [WIDTH-1:0] pinIn,
  input  logic [WIDTH-1:0] segMode,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pullEn
);
  localparam bit PER_PIN_DIR = (KIND == KIND_BIDIR);
  localparam bit OUT_ONLY    = (KIND == KIND_OUTONLY);

  logic [WIDTH-1:0] dataLatch;
  logic [WIDTH-1:0] dirReg;
  logic [WIDTH-1:0] pullReg;
  logic [WIDTH-1:0] dirNext;
  logic [WIDTH-1:0] dirEff;
  logic [WIDTH-1:0] portView;

  // Direction storage: full mask or only the group/control bit
  generate
    if (PER_PIN_DIR) begin : gPerPin
      assign dirNext = busWrData;
      assign dirEff  = dirReg;
    end else begin : gGroup
      assign dirNext = {{(WIDTH-1){1'b0}}, busWrData[0]};
      assign dirEff  = {WIDTH{dirReg[0]}};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataLatch <= '0;
      dirReg    <= '0;
      pullReg   <= '0;
    end else begin
      if (strobe.wrData) dataLatch <= busWrData;
      if (strobe.wrDir)  dirReg    <= dirNext;
      if (strobe.wrPull) pullReg   <= busWrData;
    end
  end

  assign pinOe  = dirEff;
  assign pinOut = dataLatch;

  // Per-pin pull-up gating and read view
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : gPin
      if (OUT_ONLY) begin : gOut
        assign pullEn[i]   = ~dirReg[0];
        assign portView[i] = dataLatch[i];
      end else begin : gBi
        assign pullEn[i]   = pullReg[i] & ~dirEff[i] & ~segMode[i];
        assign portView[i] = dirEff[i] ? dataLatch[i] : pinIn[i];
      end
    end
  endgenerate

  always_comb begin
    unique case (strobe.rdSel)
      SEL_DATA: busRdData = portView;
      SEL_DIR:  busRdData = dirReg;
      SEL_PULL: busRdData = pullReg;
      default:  busRdData = '0;
    endcase
  end

  // R6: a driven pin never carries a pull-up
  assert_pull_only_inputs_R6 : assert property (@(posedge clk) disable iff (!rstN)
    (pullEn & pinOe) == '0);

  // R5: a data write lands in the latch and does not touch the drivers
  assert_latch_write_R5 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrData |=> (pinOut == $past(busWrData)) && $stable(pinOe));

  generate
    if (!OUT_ONLY) begin : gBiChk
      // R7: segment pins never pulled up
      assert_seg_no_pull_R7 : assert property (@(posedge clk) disable iff (!rstN)
        (pullEn & segMode) == '0);
      // R3: output pins read back the latch
      assert_read_latch_R3 : assert property (@(posedge clk) disable iff (!rstN)
        (strobe.rdSel == SEL_DATA) |-> (((busRdData ^ pinOut) & pinOe) == '0));
      // R4: input pins read back the pin level
      assert_read_pin_R4 : assert property (@(posedge clk) disable iff (!rstN)
        (strobe.rdSel == SEL_DATA) |-> (((busRdData ^ pinIn) & ~pinOe) == '0));
    end
    if (!PER_PIN_DIR) begin : gGrpChk
      // R8: grouped drivers move together
      assert_group_uniform_R8 : assert property (@(posedge clk) disable iff (!rstN)
        (pinOe == '0) || (pinOe == '1));
    end
    if (OUT_ONLY) begin : gOutChk
      // R9: idle output-only slice floats with pull-ups
      assert_outonly_idle_R9 : assert property (@(posedge clk) disable iff (!rstN)
        (pinOe == '0) |-> (pullEn == '1));
    end
  endgenerate
endmodule

// File: rtl/gpioPortSlice.sv
module gpioPortSlice
  import gpioSlicePkg::*;
#(
  parameter int        WIDTH  = 8,
  parameter int        ADDR_W = 2,
  parameter portKind_e KIND   = KIND_BIDIR
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [WIDTH-1:0]  busWrData,
  output logic [WIDTH-1:0]  busRdData,
  input  logic [WIDTH-1:0]  pinIn,
  input  logic [WIDTH-1:0]  segMode,
  output logic [WIDTH-1:0]  pinOe,
  output logic [WIDTH-1:0]  pinOut,
  output logic [WIDTH-1:0]  pullEn
);
  sliceStrobe_t strobe;

  gpioSliceCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  gpioSliceDatapath #(.WIDTH(WIDTH), .KIND(KIND)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .pinIn     (pinIn),
    .segMode   (segMode),
    .pinOe     (pinOe),
    .pinOut    (pinOut),
    .pullEn    (pullEn)
  );
endmodule

// File: tb/gpioPortSlice_test.sv
`timescale 1ns/1ps
module gpioPortSlice_test;
  import gpioSlicePkg::*;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] pinIn = '0;
  logic [7:0] segMode = '0;
  logic [7:0] rdD [3];
  logic [7:0] oeD [3];
  logic [7:0] outD [3];
  logic [7:0] puD [3];

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  gpioPortSlice #(.KIND(KIND_BIDIR)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(rdD[0]), .pinIn(pinIn), .segMode(segMode), .pinOe(oeD[0]), .pinOut(outD[0]), .pullEn(puD[0]));
  gpioPortSlice #(.KIND(KIND_GROUPED)) uutGrp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(rdD[1]), .pinIn(pinIn), .segMode(segMode), .pinOe(oeD[1]), .pinOut(outD[1]), .pullEn(puD[1]));
  gpioPortSlice #(.KIND(KIND_OUTONLY)) uutOut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(rdD[2]), .pinIn(pinIn), .segMode(segMode), .pinOe(oeD[2]), .pinOut(outD[2]), .pullEn(puD[2]));

  // Behavioural reference: 0 per-pin, 1 grouped, 2 output-only
  logic [7:0] mLatch [3];
  logic [7:0] mDir [3];
  logic [7:0] mPull [3];

  always @(posedge clk or negedge rstN) begin
    for (int k = 0; k < 3; k++) begin
      if (!rstN) begin
        mLatch[k] <= 8'h00; mDir[k] <= 8'h00; mPull[k] <= 8'h00;
      end else if (busWrEn) begin
        if (busAddr == 2'd0) mLatch[k] <= busWrData;
        if (busAddr == 2'd1) mDir[k] <= (k == 0) ? busWrData : {7'b0, busWrData[0]};
        if (busAddr == 2'd2) mPull[k] <= busWrData;
      end
    end
  end

  function automatic logic [7:0] expOe(int k);
    return (k == 0) ? mDir[k] : {8{mDir[k][0]}};
  endfunction

  function automatic logic [7:0] expPull(int k);
    if (k == 2) return mDir[k][0] ? 8'h00 : 8'hFF;
    return mPull[k] & ~expOe(k) & ~segMode;
  endfunction

  function automatic logic [7:0] expRd(int k);
    case (busAddr)
      2'd0: return (k == 2) ? mLatch[k] : ((mLatch[k] & expOe(k)) | (pinIn & ~expOe(k)));
      2'd1: return mDir[k];
      2'd2: return mPull[k];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at %0t: got %02h expected %02h", req, $time, got, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      for (int k = 0; k < 3; k++) begin
        check("R3 R4 R10 read", rdD[k], expRd(k));
        check("R2 R8 R9 drive", oeD[k], expOe(k));
        check("R5 latch", outD[k], mLatch[k]);
        check("R6 R7 R9 pull", puD[k], expPull(k));
      end
    end
  end

  task automatic busWrite(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #1;
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic look(logic [1:0] a);
    @(posedge clk); #1;
    busAddr = a; busWrEn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: reset state
    look(2'd0);
    check("R1 per-pin oe", oeD[0], 8'h00);
    check("R1 out-only oe", oeD[2], 8'h00);
    check("R1 out-only pull", puD[2], 8'hFF);
    check("R1 per-pin pull", puD[0], 8'h00);
    look(2'd1);
    check("R1 dir", rdD[0], 8'h00);
    look(2'd2);
    check("R1 pull reg", rdD[0], 8'h00);

    // R2, R8: direction
    busWrite(2'd1, 8'h0F);
    look(2'd1);
    check("R2 per-pin oe", oeD[0], 8'h0F);
    check("R8 grouped oe", oeD[1], 8'hFF);
    check("R8 grouped dir read", rdD[1], 8'h01);

    // R3, R4, R11: read paths
    busWrite(2'd0, 8'hA5);
    pinIn = 8'h3C;
    look(2'd0);
    check("R3 R4 mixed read", rdD[0], 8'h35);
    check("R11 out-only read", rdD[2], 8'hA5);
    check("R9 out-only drives latch", outD[2] & oeD[2], 8'hA5);

    // R5: write while input
    busWrite(2'd1, 8'h00);
    busWrite(2'd0, 8'h5A);
    look(2'd0);
    check("R5 stays undriven", oeD[0], 8'h00);
    check("R5 reads pin", rdD[0], 8'h3C);
    check("R5 latch on pinOut", outD[0], 8'h5A);
    busWrite(2'd1, 8'hFF);
    look(2'd0);
    check("R5 latch driven later", rdD[0], 8'h5A);

    // R6, R7: pull-up gating
    busWrite(2'd1, 8'hF0);
    busWrite(2'd2, 8'hFF);
    look(2'd2);
    check("R6 pull inputs only", puD[0], 8'h0F);
    segMode = 8'h03;
    look(2'd2);
    check("R7 seg override", puD[0], 8'h0C);
    check("R7 grouped seg", puD[1], 8'hFC);

    // R9: output-only idle
    check("R9 idle pull", puD[2], 8'hFF);
    check("R9 idle oe", oeD[2], 8'h00);

    // R10: unused offset
    busWrite(2'd3, 8'hEE);
    look(2'd3);
    check("R10 offset 3 zero", rdD[0], 8'h00);
    look(2'd1);
    check("R10 dir readback", rdD[0], 8'hF0);

    // Random traffic compared every cycle
    for (int n = 0; n < 2000; n++) begin
      @(posedge clk); #1;
      busAddr   = 2'($urandom);
      busWrData = 8'($urandom);
      busWrEn   = ($urandom % 3) == 0;
      pinIn     = 8'($urandom);
      segMode   = ($urandom % 2) ? 8'($urandom) : 8'h00;
    end
    @(posedge clk); #1 busWrEn = 1'b0;
    @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule